// File: doc/BRIEF.md
# Character LCD nibble transfer engine

This block sends command and character bytes to a character LCD module wired in 4-bit, write-only mode. A client offers one byte plus a register-select flag on a valid/ready handshake. The engine then drives the 4-bit data bus, the register-select line and the enable strobe with the setup, pulse-width and inter-nibble spacing that the display controller needs. Each byte goes out as two nibble writes, high nibble first.

After the second strobe the engine keeps its ready output low until the display has had time to execute the byte. A clear-display command (register select low, byte value 0x01) takes far longer to execute, so the engine picks the long wait for that byte on its own. The client never has to count cycles. All timing is given in nanoseconds and converted to clock cycles from a clock-frequency parameter, which is 50 MHz by default. The read/write line is a constant low. Power-up initialization, busy-flag reads and display reads are left to the client or to other logic.

Top module: `lcd_nibble_tx`

## Requirements
- R1: After reset, `in_ready` is 1, `lcd_en` is 0 and `lcd_rw` is 0, and no enable strobe occurs until a byte has been accepted.
- R2: A byte is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. It produces exactly two enable strobes: the first presents `in_byte[7:4]` on `lcd_d`, the second presents `in_byte[3:0]`. `lcd_rs` equals the accepted `in_rs` during both strobes.
- R3: Each rising edge of `lcd_en` comes at least SETUP_CYC = ceil(40 ns × CLK_HZ) cycles (minimum 1) after `lcd_d` or `lcd_rs` last changed.
- R4: `lcd_en` stays high for exactly PULSE_CYC = ceil(230 ns × CLK_HZ) cycles on every strobe.
- R5: The second strobe of a byte rises exactly GAP_CYC = max(ceil(1 µs × CLK_HZ), SETUP_CYC + 1) cycles after the first strobe falls.
- R6: `lcd_d` and `lcd_rs` do not change while `lcd_en` is high, nor in the first cycle after `lcd_en` falls.
- R7: For an ordinary byte, `in_ready` returns to 1 exactly POST_CYC = ceil(40 µs × CLK_HZ) cycles after the second strobe falls.
- R8: For a clear-display command (`in_rs` = 0 and `in_byte` = 0x01), `in_ready` returns to 1 exactly CLEAR_CYC = ceil(1.64 ms × CLK_HZ) cycles after the second strobe falls.
- R9: The byte 0x01 with `in_rs` = 1, and any other byte with `in_rs` = 0, use the ordinary POST_CYC wait.
- R10: `lcd_rw` is 0 in every cycle.
- R11: `in_ready` is 0 from the cycle after an accept until its wait ends. `in_valid` asserted while `in_ready` is 0 is ignored: it produces no strobe and does not change the bytes sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ hertz |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Client offers a byte |
| in_ready | output | 1 | Engine can take a byte this cycle |
| in_rs | input | 1 | Register select of the offered byte (0 = command, 1 = data) |
| in_byte | input | 8 | Byte to send |
| lcd_d | output | 4 | Display data bus, one nibble at a time |
| lcd_rs | output | 1 | Display register select |
| lcd_en | output | 1 | Display enable strobe, active high |
| lcd_rw | output | 1 | Display read/write, always 0 (write) |

## Verification
The hardest case to reach from the ports is the choice between the long and short wait. It depends on both the register-select flag and the exact byte value, so the stimulus sends 0x01 as a command, 0x01 as data, and neighbouring command bytes such as 0x00. The scoreboard times each ready rise against the wait it expects for that byte. A second awkward case is a client that keeps `in_valid` high while the engine is busy. The stimulus holds a different byte on the bus during the inter-nibble gap and the post-write wait, and the monitor rejects any strobe that was not queued by the driver. The bench runs with a 10 MHz timing parameter, so the 1.64 ms wait fits into a short run while setup and pulse lengths still span several cycles.

// File: rtl/lcd_nib_pkg.sv
package lcd_nib_pkg;

  // Phases of one byte transfer
  typedef enum logic [2:0] {
    PH_IDLE,   // waiting for a byte
    PH_SETUP,  // high nibble on bus, enable low
    PH_PULSE,  // enable high
    PH_GAP,    // between the two nibbles
    PH_POST    // execution wait after the second nibble
  } phase_t;

  localparam logic [7:0] CMD_CLEAR = 8'h01;

  // Round a duration in ns up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                            input longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Clear-display needs the long execution wait
  function automatic logic is_clear(input logic rs, input logic [7:0] b);
    return (!rs) && (b == CMD_CLEAR);
  endfunction

  function automatic logic [3:0] nibble_of(input logic [7:0] b, input logic low);
    return low ? b[3:0] : b[7:4];
  endfunction

endpackage

// File: rtl/lcd_nib_timer.sv
module lcd_nib_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_nib_seq.sv
module lcd_nib_seq
  import lcd_nib_pkg::*;
#(
  parameter int unsigned CNT_W     = 17,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 12,
  parameter int unsigned GAP_CYC   = 50,
  parameter int unsigned POST_CYC  = 2000,
  parameter int unsigned CLEAR_CYC = 82000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_rs,
  input  logic [7:0]       in_byte,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             busy,
  output logic             ev_accept,
  output logic             ev_rise,
  output logic             ev_fall,
  output logic             ev_swap
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_POST  = CNT_W'(POST_CYC - 1);
  localparam logic [CNT_W-1:0] LD_CLEAR = CNT_W'(CLEAR_CYC - 1);

  phase_t phase_q, phase_d;
  logic   low_q;      // second nibble in flight
  logic   gap_new_q;  // first cycle of the inter-nibble gap
  logic   clr_q;      // byte in flight is a clear-display command

  // Named events, shared with the pin register and the checker
  assign ev_accept = (phase_q == PH_IDLE) && in_valid;
  assign ev_rise   = ((phase_q == PH_SETUP) || (phase_q == PH_GAP)) && tmr_zero;
  assign ev_fall   = (phase_q == PH_PULSE) && tmr_zero;
  assign ev_swap   = (phase_q == PH_GAP) && gap_new_q;
  assign busy      = (phase_q != PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase_q)
      PH_IDLE: if (ev_accept) begin
        phase_d  = PH_SETUP;
        tmr_load = 1'b1;
        tmr_val  = LD_SETUP;
      end
      PH_SETUP, PH_GAP: if (ev_rise) begin
        phase_d  = PH_PULSE;
        tmr_load = 1'b1;
        tmr_val  = LD_PULSE;
      end
      PH_PULSE: if (ev_fall) begin
        tmr_load = 1'b1;
        if (low_q) begin
          phase_d = PH_POST;
          tmr_val = clr_q ? LD_CLEAR : LD_POST;
        end else begin
          phase_d = PH_GAP;
          tmr_val = LD_GAP;
        end
      end
      PH_POST: if (tmr_zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      low_q     <= 1'b0;
      gap_new_q <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (ev_accept) begin
        low_q <= 1'b0;
        clr_q <= is_clear(in_rs, in_byte);
      end
      if (ev_fall && !low_q) gap_new_q <= 1'b1;
      else if (ev_swap)      gap_new_q <= 1'b0;
      if (ev_rise && (phase_q == PH_GAP)) low_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lcd_nib_pins.sv
module lcd_nib_pins
  import lcd_nib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_accept,
  input  logic       ev_swap,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic       in_rs,
  input  logic [7:0] in_byte,
  output logic [3:0] lcd_d,
  output logic       lcd_rs,
  output logic       lcd_en
);

  logic [7:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      lcd_d  <= '0;
      lcd_rs <= 1'b0;
      lcd_en <= 1'b0;
    end else begin
      if (ev_accept) begin
        byte_q <= in_byte;
        lcd_rs <= in_rs;
        lcd_d  <= nibble_of(in_byte, 1'b0);
      end else if (ev_swap) begin
        lcd_d  <= nibble_of(byte_q, 1'b1);
      end
      if (ev_rise)      lcd_en <= 1'b1;
      else if (ev_fall) lcd_en <= 1'b0;
    end
  end

endmodule

// File: rtl/lcd_nibble_tx.sv
module lcd_nibble_tx
  import lcd_nib_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned SETUP_NS = 40,
  parameter int unsigned PULSE_NS = 230,
  parameter int unsigned GAP_NS   = 1_000,
  parameter int unsigned POST_NS  = 40_000,
  parameter int unsigned CLEAR_NS = 1_640_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_rs,
  input  logic [7:0] in_byte,
  output logic [3:0] lcd_d,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic       lcd_rw
);

  localparam int unsigned SETUP_CYC = ns_to_cyc(64'(SETUP_NS), 64'(CLK_HZ));
  localparam int unsigned PULSE_CYC = ns_to_cyc(64'(PULSE_NS), 64'(CLK_HZ));
  localparam int unsigned GAP_CYC   = max_u(ns_to_cyc(64'(GAP_NS), 64'(CLK_HZ)), SETUP_CYC + 1);
  localparam int unsigned POST_CYC  = ns_to_cyc(64'(POST_NS), 64'(CLK_HZ));
  localparam int unsigned CLEAR_CYC = ns_to_cyc(64'(CLEAR_NS), 64'(CLK_HZ));
  localparam int unsigned MAX_CYC   = max_u(max_u(CLEAR_CYC, POST_CYC),
                                            max_u(GAP_CYC, PULSE_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic             tmr_zero, tmr_load, busy;
  logic [CNT_W-1:0] tmr_val;
  logic             ev_accept, ev_rise, ev_fall, ev_swap;

  lcd_nib_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  lcd_nib_seq #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC),
    .POST_CYC  (POST_CYC),
    .CLEAR_CYC (CLEAR_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_rs     (in_rs),
    .in_byte   (in_byte),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .busy      (busy),
    .ev_accept (ev_accept),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .ev_swap   (ev_swap)
  );

  lcd_nib_pins u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_accept (ev_accept),
    .ev_swap   (ev_swap),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .in_rs     (in_rs),
    .in_byte   (in_byte),
    .lcd_d     (lcd_d),
    .lcd_rs    (lcd_rs),
    .lcd_en    (lcd_en)
  );

  assign in_ready = !busy;
  assign lcd_rw   = 1'b0;

endmodule

// File: rtl/lcd_nib_chk.sv
module lcd_nib_chk #(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] lcd_d,
  input logic       lcd_rs,
  input logic       lcd_en,
  input logic       lcd_rw
);

  logic [31:0] hi_cnt;    // cycles enable has been high
  logic [31:0] stab_cnt;  // cycles bus has held its value
  logic [4:0]  last_bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      stab_cnt <= 32'hFFFF_FFFF;
      last_bus <= '0;
    end else begin
      hi_cnt   <= lcd_en ? hi_cnt + 1 : '0;
      last_bus <= {lcd_rs, lcd_d};
      if ({lcd_rs, lcd_d} != last_bus) stab_cnt <= 32'd1;
      else if (stab_cnt != 32'hFFFF_FFFF) stab_cnt <= stab_cnt + 1;
    end
  end

  AST_RW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_rw == 1'b0);  // R10
  AST_SETUP_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> stab_cnt >= SETUP_CYC);  // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> hi_cnt == PULSE_CYC);  // R4
  AST_HOLD_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> ($stable(lcd_d) && $stable(lcd_rs)));  // R6
  AST_HOLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> ($stable(lcd_d) && $stable(lcd_rs)));  // R6
  AST_BUSY_WHILE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !in_ready);  // R11
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);  // R11

endmodule

bind lcd_nibble_tx lcd_nib_chk #(
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .lcd_d    (lcd_d),
  .lcd_rs   (lcd_rs),
  .lcd_en   (lcd_en),
  .lcd_rw   (lcd_rw)
);

// File: tb/test_lcd_nibble_tx.sv
`timescale 1ns/1ps
module test_lcd_nibble_tx;

  // Timing at a 10 MHz parameter, rounded up from the requirement durations
  localparam int TB_HZ = 10_000_000;
  localparam int T_SETUP = 1;      // 40 ns
  localparam int T_PULSE = 3;      // 230 ns
  localparam int T_GAP   = 10;     // 1 us
  localparam int T_POST  = 400;    // 40 us
  localparam int T_CLEAR = 16400;  // 1.64 ms

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_rs = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_ready;
  logic [3:0] lcd_d;
  logic       lcd_rs, lcd_en, lcd_rw;

  always #2.5 clk = ~clk;

  lcd_nibble_tx #(.CLK_HZ(TB_HZ)) i_lcd_nibble_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_rs(in_rs), .in_byte(in_byte), .lcd_d(lcd_d), .lcd_rs(lcd_rs),
    .lcd_en(lcd_en), .lcd_rw(lcd_rw)
  );

  int checks = 0;
  int errors = 0;
  int bytes_sent = 0;
  int strobes = 0;
  logic [5:0] nq[$];   // {low flag, rs, nibble}
  int         wq[$];   // expected post wait per byte
  bit mon_on = 1'b0;
  bit waiting = 1'b0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Driver: offer one byte, queue what the display should see
  task automatic send(input logic rs, input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_rs    = rs;
    in_byte  = b;
    nq.push_back({1'b0, rs, b[7:4]});
    nq.push_back({1'b1, rs, b[3:0]});
    wq.push_back((!rs && b == 8'h01) ? T_CLEAR : T_POST);  // R8 R9
    bytes_sent++;
    @(negedge clk);
    in_valid = 1'b0;
    in_byte  = ~b;
    in_rs    = ~rs;
    chk(in_ready == 1'b0, "R11 ready low after accept", in_ready, 0);
  endtask

  // Monitor: compare strobes and timing against the queues
  logic       prev_en = 1'b0;
  logic [4:0] prev_bus = '0;
  int cyc = 0, since_chg = 1000, hi_len = 0, fall_cyc = 0, wcnt = 0, cur_wait = 0;
  logic [5:0] cur;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if ({lcd_rs, lcd_d} != prev_bus) begin
        if (prev_en) chk(1'b0, "R6 bus changed during or right after strobe", lcd_d, prev_bus[3:0]);
        since_chg = 0;
      end else begin
        since_chg++;
      end
      if (lcd_en && !prev_en) begin
        strobes++;
        hi_len = 1;
        chk(lcd_rw == 1'b0, "R10 rw low at strobe", lcd_rw, 0);
        chk(since_chg >= T_SETUP, "R3 setup before enable", since_chg, T_SETUP);
        if (nq.size() == 0) begin
          chk(1'b0, "R11 unexpected strobe", strobes, bytes_sent * 2);
          cur = 6'h0;
        end else begin
          cur = nq.pop_front();
          chk(lcd_d == cur[3:0], "R2 nibble value", lcd_d, cur[3:0]);
          chk(lcd_rs == cur[4], "R2 register select", lcd_rs, cur[4]);
          if (cur[5]) chk(cyc - fall_cyc == T_GAP, "R5 nibble gap", cyc - fall_cyc, T_GAP);
        end
      end else if (lcd_en) begin
        hi_len++;
      end
      if (!lcd_en && prev_en) begin
        chk(hi_len == T_PULSE, "R4 enable width", hi_len, T_PULSE);
        fall_cyc = cyc;
        if (cur[5]) begin
          waiting = 1'b1;
          wcnt = 0;
          cur_wait = (wq.size() != 0) ? wq.pop_front() : -1;
        end
      end else if (waiting) begin
        wcnt++;
        if (in_ready) begin
          waiting = 1'b0;
          chk(wcnt == cur_wait,
              (cur_wait == T_CLEAR) ? "R8 clear wait" : "R7 R9 normal wait", wcnt, cur_wait);
        end
      end
      prev_en  = lcd_en;
      prev_bus = {lcd_rs, lcd_d};
    end
  end

  initial begin
    repeat (200_000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and no strobe while idle
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(lcd_en == 1'b0, "R1 enable after reset", lcd_en, 0);
    chk(lcd_rw == 1'b0, "R1 rw after reset", lcd_rw, 0);
    mon_on = 1'b1;
    repeat (20) @(negedge clk);
    chk(strobes == 0, "R1 no strobe while idle", strobes, 0);

    send(1'b0, 8'h28);
    send(1'b1, 8'h41);
    send(1'b0, 8'h01);   // clear-display: long wait
    send(1'b1, 8'h01);   // data 0x01: short wait
    send(1'b0, 8'h00);   // neighbour command: short wait
    send(1'b0, 8'h06);
    // R11: hold a foreign byte on the bus while busy
    repeat (30) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_rs    = 1'b1;
      in_byte  = 8'h5A;
    end
    chk(in_ready == 1'b0, "R11 still busy under held valid", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    send(1'b1, 8'hFF);
    send(1'b1, 8'h00);
    send(1'b0, 8'h0C);

    @(negedge clk);
    while (nq.size() != 0 || waiting || !in_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(strobes == bytes_sent * 2, "R2 R11 strobe count", strobes, bytes_sent * 2);
    chk(wq.size() == 0, "R7 all waits observed", wq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule